// File: doc/BRIEF.md
# Iterative Block Cipher Sequencing Controller

This block is the control unit for an iterative block-cipher datapath built for 32-bit words, twelve rounds and a 64-bit data block. A data source hands it one block at a time through a write strobe. A full flag tells the source when the input buffer cannot take another block. The controller moves the buffered block into the datapath. It then steps a round counter whose value is the address of a precomputed round-key memory, and it raises a data-available flag once the result sits in the output buffer. The result stays there until the sink pulses a read strobe.

Each block carries its own direction bit, which is sampled together with the data. For encryption, the key-addition step with round key 0 comes first and is followed by rounds 1 to 12. For decryption, rounds 12 down to 1 come first and the key-addition step with key 0 comes last. The input buffer is emptied as soon as the datapath has loaded it, so the next block can be written while the current one is still being processed. That block is started only when the controller is back in its idle state. The cipher arithmetic and the key memory are simple stand-in models, so the control sequence can be checked against known values.

Top module: `cipher_seq_ctrl`

## Requirements
- R1: After reset, buf_full, data_avail and round_no are 0 and rd_data is all zeros.
- R2: At a rising edge, a write is accepted when wr_strobe is 1 and buf_full is 0. It captures wr_data and mode_dec, and buf_full reads 1 after that edge. buf_full stays 1 until the edge at which the datapath loads the block, which is the second edge after the write when the controller is idle, and it reads 0 after that edge.
- R3: A write strobe seen while buf_full is 1 is ignored. The buffered block, its direction and its result do not change.
- R4: With mode_dec = 0 (encrypt), round_no reads 0 after the second edge following an accepted write from idle, while key 0 is added. It then reads 1, 2, … 12 after edges 3 through 14.
- R5: With mode_dec = 1 (decrypt), round_no reads 12, 11, … 1 after edges 2 through 13 following an accepted write from idle. It reads 0 after edge 14, for the closing key-0 addition.
- R6: data_avail becomes 1 exactly ROUNDS+4 edges (16) after an accepted write from idle. rd_data then equals the stand-in cipher result. Round key i is formed of two 32-bit words: word g (g = 0 in bits 31:0, g = 1 in bits 63:32) equals (2i+g+1)·0x9E3779B9 mod 2^32. Encryption XORs key 0 into the block, then for i = 1..12 sets each word to rotate-left-by-3 of (word XOR key word). Decryption, for i = 12..1, sets each word to rotate-right-by-3 of the word, XOR key word, and then XORs key 0 into the block.
- R7: While data_avail is 1 and rd_strobe is 0, data_avail stays 1 and rd_data does not change.
- R8: When data_avail is 1 and rd_strobe is 1 at a rising edge, data_avail reads 0 after that edge and the controller is idle. A block already waiting in the input buffer then yields its result ROUNDS+4 edges after that read edge.
- R9: Changing mode_dec after a block has been accepted has no effect on that block. Decrypting a ciphertext produced by the block returns the original plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; returns the controller to idle |
| mode_dec | input | 1 | Direction for the block being written: 0 encrypt, 1 decrypt |
| wr_strobe | input | 1 | Source write request, taken when buf_full is 0 |
| wr_data | input | 64 | Block offered by the source |
| buf_full | output | 1 | Input buffer occupied; writes are ignored |
| rd_strobe | input | 1 | Sink read acknowledge for the held result |
| rd_data | output | 64 | Result held in the output buffer |
| data_avail | output | 1 | Result present in the output buffer |
| round_no | output | 4 | Current round index, used as the round-key memory address |

## Verification
The assertions take for granted that every strobe and mode_dec is a clean 0 or 1 at each rising edge, and that reset is applied once before any traffic. They do not require rd_strobe to be a single pulse or to be raised only while data_avail is 1, because the controller ignores a read that comes with no result. The stimulus changes inputs only on falling edges. It lowers each strobe one edge after it is seen, except for the write deliberately held high into a full buffer. It flips mode_dec in the middle of a block to show that the captured direction is the one used.

// File: rtl/cseq_pkg.sv
package cseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_LOAD    = 3'd1,
      ST_INIT    = 3'd2,
      ST_ROUND   = 3'd3,
      ST_DONE    = 3'd4,
      ST_WAIT_RD = 3'd5
   } cseq_state_e;

   typedef enum logic {
      DIR_ENC = 1'b0,
      DIR_DEC = 1'b1
   } cseq_dir_e;

endpackage

// File: rtl/cseq_in_buf.sv
module cseq_in_buf #(
   parameter int BLK_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_strobe,
   input  logic [BLK_W-1:0] wr_data,
   input  logic             mode_in,
   input  logic             take,
   output logic             full,
   output logic [BLK_W-1:0] blk,
   output logic             blk_dec
);

   logic accept;

   assign accept = wr_strobe && !full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         blk     <= '0;
         blk_dec <= 1'b0;
      end else begin
         if (accept) begin
            blk     <= wr_data;
            blk_dec <= mode_in;
         end
         if (accept) begin
            full <= 1'b1;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cseq_round_ctr.sv
module cseq_round_ctr #(
   parameter int ROUNDS = 12,
   localparam int RND_W = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [RND_W-1:0] set_val,
   input  logic             up_en,
   input  logic             dn_en,
   output logic [RND_W-1:0] cnt,
   output logic             at_top,
   output logic             at_one
);

   localparam logic [RND_W-1:0] TOP = RND_W'(ROUNDS);
   localparam logic [RND_W-1:0] ONE = RND_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (set_en) begin
         cnt <= set_val;
      end else if (up_en) begin
         cnt <= cnt + ONE;
      end else if (dn_en) begin
         cnt <= cnt - ONE;
      end
   end

   assign at_top = (cnt == TOP);
   assign at_one = (cnt == ONE);

endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
   import cseq_pkg::*;
#(
   parameter int ROUNDS = 12,
   localparam int RND_W = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             buf_full,
   input  logic             buf_dec,
   input  logic             rd_strobe,
   input  logic             cnt_top,
   input  logic             cnt_one,
   output cseq_state_e      state,
   output cseq_dir_e        dir,
   output logic             take,
   output logic             dp_load,
   output logic             dp_init,
   output logic             dp_round,
   output logic             out_cap,
   output logic             cnt_set,
   output logic [RND_W-1:0] cnt_val,
   output logic             cnt_up,
   output logic             cnt_dn
);

   cseq_state_e nxt;
   cseq_dir_e   buf_dir;

   assign buf_dir = buf_dec ? DIR_DEC : DIR_ENC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         dir   <= DIR_ENC;
      end else begin
         state <= nxt;
         if (state == ST_LOAD) begin
            dir <= buf_dir;
         end
      end
   end

   always_comb begin
      nxt      = state;
      take     = 1'b0;
      dp_load  = 1'b0;
      dp_init  = 1'b0;
      dp_round = 1'b0;
      out_cap  = 1'b0;
      cnt_set  = 1'b0;
      cnt_val  = '0;
      cnt_up   = 1'b0;
      cnt_dn   = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (buf_full) begin
               nxt = ST_LOAD;
            end
         end
         ST_LOAD: begin
            take    = 1'b1;
            dp_load = 1'b1;
            cnt_set = 1'b1;
            if (buf_dir == DIR_DEC) begin
               cnt_val = RND_W'(ROUNDS);
               nxt     = ST_ROUND;
            end else begin
               cnt_val = '0;
               nxt     = ST_INIT;
            end
         end
         ST_INIT: begin
            dp_init = 1'b1;
            if (dir == DIR_ENC) begin
               cnt_up = 1'b1;
               nxt    = ST_ROUND;
            end else begin
               nxt = ST_DONE;
            end
         end
         ST_ROUND: begin
            dp_round = 1'b1;
            if (dir == DIR_ENC) begin
               if (cnt_top) begin
                  nxt = ST_DONE;
               end else begin
                  cnt_up = 1'b1;
               end
            end else begin
               cnt_dn = 1'b1;
               if (cnt_one) begin
                  nxt = ST_INIT;
               end
            end
         end
         ST_DONE: begin
            out_cap = 1'b1;
            nxt     = ST_WAIT_RD;
         end
         ST_WAIT_RD: begin
            if (rd_strobe) begin
               nxt = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/cseq_key_rom.sv
module cseq_key_rom #(
   parameter int                WORD_W   = 32,
   parameter int                ROUNDS   = 12,
   parameter logic [WORD_W-1:0] KEY_MULT = WORD_W'(32'h9E3779B9),
   localparam int               RND_W    = $clog2(ROUNDS + 1),
   localparam int               N_WORDS  = 2,
   localparam int               BLK_W    = N_WORDS * WORD_W
) (
   input  logic [RND_W-1:0] addr,
   output logic [BLK_W-1:0] key
);

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] idx;
      assign idx = (WORD_W'(addr) << 1) + WORD_W'(g + 1);
      assign key[g*WORD_W +: WORD_W] = idx * KEY_MULT;
   end

endmodule

// File: rtl/cseq_dp_stub.sv
module cseq_dp_stub
   import cseq_pkg::*;
#(
   parameter int  WORD_W  = 32,
   parameter int  ROT_AMT = 3,
   localparam int N_WORDS = 2,
   localparam int BLK_W   = N_WORDS * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             init_step,
   input  logic             round_step,
   input  cseq_dir_e        dir,
   input  logic [BLK_W-1:0] blk_in,
   input  logic [BLK_W-1:0] key,
   output logic [BLK_W-1:0] q
);

   logic [BLK_W-1:0] step;

   for (genvar g = 0; g < N_WORDS; g++) begin : g_word
      logic [WORD_W-1:0] w, k, mix, fwd, bwd, rot_r;
      assign w     = q[g*WORD_W +: WORD_W];
      assign k     = key[g*WORD_W +: WORD_W];
      assign mix   = w ^ k;
      assign fwd   = (mix << ROT_AMT) | (mix >> (WORD_W - ROT_AMT));
      assign rot_r = (w >> ROT_AMT) | (w << (WORD_W - ROT_AMT));
      assign bwd   = rot_r ^ k;
      always_comb begin
         if (init_step) begin
            step[g*WORD_W +: WORD_W] = mix;
         end else if (dir == DIR_DEC) begin
            step[g*WORD_W +: WORD_W] = bwd;
         end else begin
            step[g*WORD_W +: WORD_W] = fwd;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= blk_in;
      end else if (init_step || round_step) begin
         q <= step;
      end
   end

endmodule

// File: rtl/cseq_out_buf.sv
module cseq_out_buf #(
   parameter int BLK_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap,
   input  logic [BLK_W-1:0] res,
   input  logic             rd_strobe,
   output logic             avail,
   output logic [BLK_W-1:0] data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         avail <= 1'b0;
         data  <= '0;
      end else if (cap) begin
         avail <= 1'b1;
         data  <= res;
      end else if (avail && rd_strobe) begin
         avail <= 1'b0;
      end
   end

endmodule

// File: rtl/cipher_seq_ctrl.sv
module cipher_seq_ctrl
   import cseq_pkg::*;
#(
   parameter int                WORD_W   = 32,
   parameter int                ROUNDS   = 12,
   parameter int                ROT_AMT  = 3,
   parameter logic [WORD_W-1:0] KEY_MULT = WORD_W'(32'h9E3779B9),
   localparam int               BLK_W    = 2 * WORD_W,
   localparam int               RND_W    = $clog2(ROUNDS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_dec,
   input  logic             wr_strobe,
   input  logic [BLK_W-1:0] wr_data,
   output logic             buf_full,
   input  logic             rd_strobe,
   output logic [BLK_W-1:0] rd_data,
   output logic             data_avail,
   output logic [RND_W-1:0] round_no
);

   if (WORD_W < 8 || WORD_W > 64) begin : g_bad_word
      $error("cipher_seq_ctrl: WORD_W must lie in 8..64");
   end
   if (ROUNDS < 1) begin : g_bad_rounds
      $error("cipher_seq_ctrl: ROUNDS must be at least 1");
   end
   if (ROT_AMT < 1 || ROT_AMT >= WORD_W) begin : g_bad_rot
      $error("cipher_seq_ctrl: ROT_AMT must lie in 1..WORD_W-1");
   end

   logic             buf_dec, take;
   logic [BLK_W-1:0] buf_blk, round_key, dp_q;
   logic             dp_load, dp_init, dp_round, out_cap;
   logic             cnt_set, cnt_up, cnt_dn, cnt_top, cnt_one;
   logic [RND_W-1:0] cnt_val;
   cseq_state_e      fsm_state;
   cseq_dir_e        fsm_dir;

   cseq_in_buf #(.BLK_W(BLK_W)) u_in (
      .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .wr_data(wr_data),
      .mode_in(mode_dec), .take(take), .full(buf_full), .blk(buf_blk),
      .blk_dec(buf_dec)
   );

   cseq_fsm #(.ROUNDS(ROUNDS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .buf_full(buf_full), .buf_dec(buf_dec),
      .rd_strobe(rd_strobe), .cnt_top(cnt_top), .cnt_one(cnt_one),
      .state(fsm_state), .dir(fsm_dir), .take(take), .dp_load(dp_load),
      .dp_init(dp_init), .dp_round(dp_round), .out_cap(out_cap),
      .cnt_set(cnt_set), .cnt_val(cnt_val), .cnt_up(cnt_up), .cnt_dn(cnt_dn)
   );

   cseq_round_ctr #(.ROUNDS(ROUNDS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .set_en(cnt_set), .set_val(cnt_val),
      .up_en(cnt_up), .dn_en(cnt_dn), .cnt(round_no), .at_top(cnt_top),
      .at_one(cnt_one)
   );

   cseq_key_rom #(.WORD_W(WORD_W), .ROUNDS(ROUNDS), .KEY_MULT(KEY_MULT)) u_key (
      .addr(round_no), .key(round_key)
   );

   cseq_dp_stub #(.WORD_W(WORD_W), .ROT_AMT(ROT_AMT)) u_dp (
      .clk(clk), .rst_n(rst_n), .load(dp_load), .init_step(dp_init),
      .round_step(dp_round), .dir(fsm_dir), .blk_in(buf_blk),
      .key(round_key), .q(dp_q)
   );

   cseq_out_buf #(.BLK_W(BLK_W)) u_out (
      .clk(clk), .rst_n(rst_n), .cap(out_cap), .res(dp_q),
      .rd_strobe(rd_strobe), .avail(data_avail), .data(rd_data)
   );

endmodule

// File: rtl/cseq_checker.sv
module cseq_checker
   import cseq_pkg::*;
#(
   parameter int  ROUNDS = 12,
   parameter int  BLK_W  = 64,
   localparam int RND_W  = $clog2(ROUNDS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_strobe,
   input logic             rd_strobe,
   input logic             buf_full,
   input logic             data_avail,
   input logic [BLK_W-1:0] rd_data,
   input logic [RND_W-1:0] round_no,
   input cseq_state_e      state,
   input cseq_dir_e        dir,
   input logic [BLK_W-1:0] buf_blk
);

   localparam logic [RND_W-1:0] TOP = RND_W'(ROUNDS);
   localparam logic [RND_W-1:0] ONE = RND_W'(1);

   assert_full_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_strobe && !buf_full |=> buf_full);

   assert_full_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full && state != ST_LOAD |=> buf_full);

   assert_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full && wr_strobe |=> $stable(buf_blk));

   assert_init_key0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_INIT |-> round_no == '0);

   assert_enc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ROUND && dir == DIR_ENC && round_no != TOP
      |=> round_no == $past(round_no) + ONE);

   assert_dec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_ROUND && dir == DIR_DEC
      |=> round_no == $past(round_no) - ONE);

   assert_round_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      round_no <= TOP);

   assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_avail && !rd_strobe |=> data_avail && $stable(rd_data));

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      data_avail && rd_strobe |=> !data_avail && state == ST_IDLE);

endmodule

bind cipher_seq_ctrl cseq_checker #(.ROUNDS(ROUNDS), .BLK_W(BLK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
   .buf_full(buf_full), .data_avail(data_avail), .rd_data(rd_data),
   .round_no(round_no), .state(fsm_state), .dir(fsm_dir), .buf_blk(buf_blk)
);

// File: tb/cipher_seq_ctrl_bench.sv
`timescale 1ns/1ps
module cipher_seq_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_dec = 1'b0;
   logic        wr_strobe = 1'b0;
   logic [63:0] wr_data = '0;
   logic        rd_strobe = 1'b0;
   logic        buf_full, data_avail;
   logic [63:0] rd_data;
   logic [3:0]  round_no;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   cipher_seq_ctrl u_cipher_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_dec(mode_dec), .wr_strobe(wr_strobe),
      .wr_data(wr_data), .buf_full(buf_full), .rd_strobe(rd_strobe),
      .rd_data(rd_data), .data_avail(data_avail), .round_no(round_no)
   );

   function automatic logic [31:0] kw(input int i, input int g);
      logic [31:0] idx;
      idx = 32'(2 * i + g + 1);
      return idx * 32'h9E3779B9;
   endfunction

   function automatic logic [31:0] rl3(input logic [31:0] x);
      return {x[28:0], x[31:29]};
   endfunction

   function automatic logic [31:0] rr3(input logic [31:0] x);
      return {x[2:0], x[31:3]};
   endfunction

   function automatic logic [63:0] enc_ref(input logic [63:0] x);
      logic [31:0] lo, hi;
      lo = x[31:0] ^ kw(0, 0);
      hi = x[63:32] ^ kw(0, 1);
      for (int i = 1; i <= 12; i++) begin
         lo = rl3(lo ^ kw(i, 0));
         hi = rl3(hi ^ kw(i, 1));
      end
      return {hi, lo};
   endfunction

   function automatic logic [63:0] dec_ref(input logic [63:0] x);
      logic [31:0] lo, hi;
      lo = x[31:0];
      hi = x[63:32];
      for (int i = 12; i >= 1; i--) begin
         lo = rr3(lo) ^ kw(i, 0);
         hi = rr3(hi) ^ kw(i, 1);
      end
      return {hi ^ kw(0, 1), lo ^ kw(0, 0)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(buf_full == 1'b0, "R1 buf_full", 64'(buf_full), 64'd0);
      chk(data_avail == 1'b0, "R1 data_avail", 64'(data_avail), 64'd0);
      chk(round_no == 4'd0, "R1 round_no", 64'(round_no), 64'd0);
      chk(rd_data == 64'd0, "R1 rd_data", rd_data, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // One block from idle: accepted write, ignored write while full (R3),
   // round index per cycle (R4/R5), latency and result (R6). Optionally a
   // second block is written mid-run into the freed buffer (R8), else the
   // direction input is flipped mid-run (R9).
   task automatic t_block(input logic [63:0] pt, input logic dec,
                          input logic [63:0] exp, input bit inject,
                          input logic [63:0] b_pt, input logic b_dec);
      logic [3:0] er;
      wr_data   = pt;
      mode_dec  = dec;
      wr_strobe = 1'b1;
      @(negedge clk);                 // past the write edge
      wr_data   = ~pt;                // held write into a full buffer
      mode_dec  = ~dec;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (k == 1) chk(buf_full == 1'b1, "R2 full after write", 64'(buf_full), 64'd1);
         if (k == 2) begin
            chk(buf_full == 1'b0, "R2 R3 full cleared at load", 64'(buf_full), 64'd0);
            wr_strobe = 1'b0;
            mode_dec  = dec;
         end
         if (!dec && k >= 2 && k <= 14) begin
            er = (k == 2) ? 4'd0 : 4'(k - 2);
            chk(round_no == er, "R4 encrypt round_no", 64'(round_no), 64'(er));
         end
         if (dec && k >= 2 && k <= 14) begin
            er = (k == 14) ? 4'd0 : 4'(14 - k);
            chk(round_no == er, "R5 decrypt round_no", 64'(round_no), 64'(er));
         end
         if (inject && k == 5) begin
            wr_data   = b_pt;
            mode_dec  = b_dec;
            wr_strobe = 1'b1;
         end
         if (inject && k == 6) begin
            wr_strobe = 1'b0;
            chk(buf_full == 1'b1, "R8 second block buffered", 64'(buf_full), 64'd1);
         end
         if (!inject && k == 7) mode_dec = ~dec;
         if (k == 15) chk(data_avail == 1'b0, "R6 not yet available", 64'(data_avail), 64'd0);
         if (k == 16) begin
            chk(data_avail == 1'b1, "R6 available on time", 64'(data_avail), 64'd1);
            chk(rd_data == exp, "R6 R9 result", rd_data, exp);
         end
      end
   endtask

   task automatic t_hold_read(input logic [63:0] exp);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(data_avail == 1'b1, "R7 avail held", 64'(data_avail), 64'd1);
         chk(rd_data == exp, "R7 data held", rd_data, exp);
      end
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      chk(data_avail == 1'b0, "R8 avail cleared by read", 64'(data_avail), 64'd0);
   endtask

   task automatic t_after_read(input logic [63:0] exp, input logic dec);
      logic [3:0] er;
      for (int k = 1; k <= 16; k++) begin
         @(negedge clk);
         if (k == 2) begin
            er = dec ? 4'd12 : 4'd0;
            chk(round_no == er, "R8 buffered block start", 64'(round_no), 64'(er));
         end
         if (k == 15) chk(data_avail == 1'b0, "R8 buffered not yet", 64'(data_avail), 64'd0);
         if (k == 16) begin
            chk(data_avail == 1'b1, "R8 buffered avail", 64'(data_avail), 64'd1);
            chk(rd_data == exp, "R8 buffered result", rd_data, exp);
         end
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [63:0] p1, c1, p3, p4, p5;
      p1 = 64'h0123_4567_89AB_CDEF;
      p3 = 64'hDEAD_BEEF_0000_FFFF;
      p4 = 64'h8000_0000_0000_0001;
      p5 = 64'h5A5A_A5A5_3C3C_C3C3;
      c1 = enc_ref(p1);
      @(negedge clk);
      t_reset();
      t_block(p1, 1'b0, c1, 1'b0, '0, 1'b0);
      t_hold_read(c1);
      t_block(c1, 1'b1, p1, 1'b0, '0, 1'b0);
      chk(rd_data == p1, "R9 round trip", rd_data, p1);
      t_hold_read(p1);
      t_block(p3, 1'b1, dec_ref(p3), 1'b0, '0, 1'b0);
      t_hold_read(dec_ref(p3));
      t_block(p4, 1'b0, enc_ref(p4), 1'b1, p5, 1'b1);
      t_hold_read(enc_ref(p4));
      t_after_read(dec_ref(p5), 1'b1);
      t_hold_read(dec_ref(p5));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule